// File: doc/BRIEF.md
# Indexed Generated-Clock Controller

This block gives a set of peripheral slots each its own divided clock-enable strobe. All slots sit behind a single 32-bit control word. A bus master first names a slot by writing its ID. It can then read that slot's setup back, or write a new setup with the command bit set. Each slot keeps a source select, an 8-bit divider field and an enable. The slot uses these to thin one of several single-cycle source strobes down to a slower strobe.

All source strobes and outputs belong to one clock domain. The outputs are enables for downstream logic, not clocks. A slot that is committed restarts its division. Any slot can be switched off with a command write that carries a clear enable bit.

Top module: `gclk_index_ctrl`

## Requirements
- R1: After reset every slot is disabled with source 0 and divider field 0, the selected ID is 0, `rd_data_o` is all zero and no `clk_en_o` bit is ever set while slots stay disabled.
- R2: A write with bit 12 (command) clear stores bits [6:0] as the selected ID and changes no slot setup.
- R3: A write with bit 12 set and an ID below the slot count stores bits [10:8] as source select, bits [27:20] as divider field and bit 29 as enable into that slot, and also makes that ID the selected one.
- R4: `rd_data_o` carries the selected ID in [6:0], its source select in [10:8], its divider field in [27:20] and its enable in bit 29; every other bit is zero.
- R5: During a write cycle `rd_data_o` already shows the state that holds after the write, including fields being committed in that cycle.
- R6: A command write whose ID is not below the slot count changes no slot; while such an ID is selected, `rd_data_o` is all zero.
- R7: An enabled slot with divider field D raises its `clk_en_o` bit once for every D+1 strobes of its chosen source; D=0 passes every strobe and D=255 passes one in 256.
- R8: A commit restarts the slot's count: the first output strobe follows the (D+1)-th source strobe after the commit, and appears in the cycle right after that source strobe.
- R9: A command write with bit 29 clear stops that slot's output from the following cycle on, whatever the source does.
- R10: Only the source input named by the slot's source select advances its count; strobes on other inputs have no effect on its output.
- R11: Slots divide independently; a commit to one slot leaves the count and output of every other slot undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word written |
| rd_data_o | output | 32 | Readback of the selected slot |
| src_stb_i | input | NSRC | Single-cycle source strobes |
| clk_en_o | output | NSLOT | Divided clock-enable strobe per slot |

## Verification
On every cycle the assertions check four things. Reserved readback bits stay zero. Select-only and out-of-range writes leave every slot's setup alone. A commit lands exactly the committed fields. In each slot, an output strobe only ever follows a strobe on the chosen source while the slot is enabled, and the count never passes the divider field. Some behaviour only the bench's scenarios can show. These are the exact strobe spacing for several divider values up to 256, and the restart after a commit. The bench also covers same-cycle readback forwarding, source selection against other inputs, and the independence of slots that share a source.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  localparam int WORD_W  = 32;
  localparam int ID_W    = 7;
  localparam int SRC_W   = 3;
  localparam int DIV_W   = 8;
  localparam int ID_LSB  = 0;
  localparam int SRC_LSB = 8;
  localparam int CMD_BIT = 12;
  localparam int DIV_LSB = 20;
  localparam int EN_BIT  = 29;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
  } slot_cfg_t;

  function automatic logic [WORD_W-1:0] pack_word(logic [ID_W-1:0] id, slot_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_W]   = id;
    w[SRC_LSB +: SRC_W] = c.src;
    w[DIV_LSB +: DIV_W] = c.div;
    w[EN_BIT]           = c.en;
    return w;
  endfunction

  function automatic slot_cfg_t unpack_cfg(logic [WORD_W-1:0] w);
    slot_cfg_t c;
    c.src = w[SRC_LSB +: SRC_W];
    c.div = w[DIV_LSB +: DIV_W];
    c.en  = w[EN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/gclk_regif.sv
module gclk_regif
  import gclk_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  slot_cfg_t [NSLOT-1:0] cfgs_i,
  output logic                  commit_o,
  output logic [IDX_W-1:0]      commit_idx_o,
  output slot_cfg_t             commit_cfg_o,
  output logic [WORD_W-1:0]     rd_data_o
);
  logic [ID_W-1:0] sel_q, wr_id, eff_id;
  slot_cfg_t       view_cfg;
  logic            wr_in_range, eff_in_range;

  assign wr_id        = wr_data_i[ID_LSB +: ID_W];
  assign wr_in_range  = int'(wr_id) < NSLOT;
  assign commit_o     = wr_en_i && wr_data_i[CMD_BIT] && wr_in_range;
  assign commit_idx_o = wr_id[IDX_W-1:0];
  assign commit_cfg_o = unpack_cfg(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (wr_en_i) sel_q <= wr_id;
  end

  // readback shows post-write state
  assign eff_id       = wr_en_i ? wr_id : sel_q;
  assign eff_in_range = int'(eff_id) < NSLOT;

  always_comb begin
    view_cfg = '0;
    if (commit_o)          view_cfg = commit_cfg_o;
    else if (eff_in_range) view_cfg = cfgs_i[eff_id[IDX_W-1:0]];
    rd_data_o = eff_in_range ? pack_word(eff_id, view_cfg) : '0;
  end

  logic [WORD_W-1:0] rsvd_mask;
  assign rsvd_mask = ~pack_word('1, '1);

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & rsvd_mask) == '0);

  assert_commit_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> cfgs_i[$past(commit_idx_o)] == $past(commit_cfg_o));
endmodule

// File: rtl/gclk_slot.sv
module gclk_slot
  import gclk_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int NSRC_EXT = 2 ** SRC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  slot_cfg_t       cfg_i,
  input  logic [NSRC-1:0] src_stb_i,
  output slot_cfg_t       cfg_o,
  output logic            clk_en_o
);
  slot_cfg_t            cfg_q;
  logic [DIV_W-1:0]     cnt_q;
  logic                 out_q;
  logic [NSRC_EXT-1:0]  stb_ext;
  logic                 src_hit, wrap, advance;

  assign stb_ext = NSRC_EXT'(src_stb_i);
  assign src_hit = stb_ext[cfg_q.src];
  assign wrap    = cnt_q == cfg_q.div;
  assign advance = cfg_q.en && src_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (commit_i) begin
      cfg_q <= cfg_i;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= advance && wrap;
      if (advance) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign clk_en_o = out_q;

  assert_out_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> cfg_q.en);

  assert_out_follows_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> $past(src_hit));

  assert_cnt_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en |-> cnt_q <= cfg_q.div);
endmodule

// File: rtl/gclk_index_ctrl.sv
module gclk_index_ctrl
  import gclk_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int NSRC  = 8,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic [NSRC-1:0]  src_stb_i,
  output logic [NSLOT-1:0] clk_en_o
);
  slot_cfg_t [NSLOT-1:0] cfgs;
  logic                  commit;
  logic [IDX_W-1:0]      commit_idx;
  slot_cfg_t             commit_cfg;

  gclk_regif #(.NSLOT(NSLOT)) i_regif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cfgs_i       (cfgs),
    .commit_o     (commit),
    .commit_idx_o (commit_idx),
    .commit_cfg_o (commit_cfg),
    .rd_data_o    (rd_data_o)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    gclk_slot #(.NSRC(NSRC)) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit && (int'(commit_idx) == k)),
      .cfg_i     (commit_cfg),
      .src_stb_i (src_stb_i),
      .cfg_o     (cfgs[k]),
      .clk_en_o  (clk_en_o[k])
    );
  end

  assert_select_keeps_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[CMD_BIT]) |=> $stable(cfgs));

  assert_far_id_keeps_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_data_i[ID_LSB +: ID_W]) >= NSLOT) |=> $stable(cfgs));
endmodule

// File: tb/test_gclk_index_ctrl.sv
module test_gclk_index_ctrl;
  localparam int NSLOT = 8;
  localparam int NSRC  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [31:0]      wr_data_i = '0;
  logic [31:0]      rd_data_o;
  logic [NSRC-1:0]  src_stb_i = '0;
  logic [NSLOT-1:0] clk_en_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  gclk_index_ctrl #(.NSLOT(NSLOT), .NSRC(NSRC)) i_gclk_index_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .src_stb_i (src_stb_i),
    .clk_en_o  (clk_en_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic logic [31:0] w_cmd(int id, int src, int dv, bit en);
    logic [31:0] w;
    w = '0;
    w[6:0]   = 7'(id);
    w[10:8]  = 3'(src);
    w[12]    = 1'b1;
    w[27:20] = 8'(dv);
    w[29]    = en;
    return w;
  endfunction

  function automatic logic [31:0] w_view(int id, int src, int dv, bit en);
    logic [31:0] w;
    w = w_cmd(id, src, dv, en);
    w[12] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] w_sel(int id);
    return {25'b0, 7'(id)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic step(logic [NSRC-1:0] stb, output logic [NSLOT-1:0] o);
    src_stb_i = stb;
    @(posedge clk_i); #1;
    src_stb_i = '0;
    o = clk_en_o;
  endtask

  task automatic t_reset;
    logic [NSLOT-1:0] o;
    int hits = 0;
    check("R1 readback", rd_data_o, 32'h0);
    for (int i = 0; i < 4; i++) begin
      step('1, o);
      if (o != '0) hits++;
    end
    check("R1 outputs idle", 32'(hits), 32'h0);
  endtask

  task automatic t_commit_select;
    wr(w_cmd(3, 5, 17, 1'b1));
    check("R3 commit readback", rd_data_o, w_view(3, 5, 17, 1'b1));
    wr(w_sel(6));
    check("R2 select other", rd_data_o, w_view(6, 0, 0, 1'b0));
    wr(w_sel(3));
    check("R2 select keeps cfg", rd_data_o, w_view(3, 5, 17, 1'b1));
    wr(w_cmd(3, 0, 0, 1'b0));
    check("R4 fields cleared", rd_data_o, w_view(3, 0, 0, 1'b0));
  endtask

  task automatic t_forward;
    wr_en_i = 1'b1; wr_data_i = w_cmd(5, 7, 255, 1'b1) | 32'hC00C_E080;
    #1;
    check("R5 forward commit", rd_data_o, w_view(5, 7, 255, 1'b1));
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wr_data_i = '0;
    check("R4 reserved bits zero", rd_data_o, w_view(5, 7, 255, 1'b1));
    wr_en_i = 1'b1; wr_data_i = w_sel(0);
    #1;
    check("R5 forward select", rd_data_o, w_view(0, 0, 0, 1'b0));
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    wr(w_cmd(5, 0, 0, 1'b0));
  endtask

  task automatic t_out_of_range;
    wr(w_cmd(0, 2, 9, 1'b0));
    wr(w_cmd(8, 6, 44, 1'b1));
    check("R6 far id reads zero", rd_data_o, 32'h0);
    wr(w_sel(0));
    check("R6 slot 0 untouched", rd_data_o, w_view(0, 2, 9, 1'b0));
    wr(w_cmd(127, 1, 1, 1'b1));
    wr(w_sel(7));
    check("R6 slot 7 untouched", rd_data_o, w_view(7, 0, 0, 1'b0));
    wr(w_cmd(0, 0, 0, 1'b0));
  endtask

  task automatic t_divide(int slot, int src, int dv, int n);
    logic [NSLOT-1:0] o, e;
    int errs = 0;
    wr(w_cmd(slot, src, dv, 1'b1));
    for (int k = 1; k <= n; k++) begin
      step(NSRC'(1) << src, o);
      e = ((k % (dv + 1)) == 0) ? (NSLOT'(1) << slot) : '0;
      if (o !== e) errs++;
    end
    check($sformatf("R7 divide by %0d", dv + 1), 32'(errs), 32'h0);
    wr(w_cmd(slot, 0, 0, 1'b0));
  endtask

  task automatic t_restart;
    logic [NSLOT-1:0] o;
    int early = 0;
    wr(w_cmd(1, 2, 3, 1'b1));
    step(8'h04, o);
    step(8'h04, o);
    wr(w_cmd(1, 2, 3, 1'b1));
    for (int k = 0; k < 3; k++) begin
      step(8'h04, o);
      if (o != '0) early++;
    end
    check("R8 no early strobe", 32'(early), 32'h0);
    step(8'h04, o);
    check("R8 first strobe", 32'(o), 32'h02);
    step(8'h00, o);
    check("R8 single cycle", 32'(o), 32'h0);
    wr(w_cmd(1, 0, 0, 1'b0));
  endtask

  task automatic t_disable;
    logic [NSLOT-1:0] o;
    int hits = 0;
    wr(w_cmd(4, 1, 0, 1'b1));
    step(8'h02, o);
    check("R9 enabled passes", 32'(o), 32'h10);
    wr(w_cmd(4, 1, 0, 1'b0));
    for (int k = 0; k < 5; k++) begin
      step(8'h02, o);
      if (o != '0) hits++;
    end
    check("R9 disabled silent", 32'(hits), 32'h0);
    check("R9 enable bit clear", rd_data_o, w_view(4, 1, 0, 1'b0));
  endtask

  task automatic t_source_sel;
    logic [NSLOT-1:0] o;
    int hits = 0;
    wr(w_cmd(2, 5, 0, 1'b1));
    for (int k = 0; k < 4; k++) begin
      step(8'hDF, o);
      if (o != '0) hits++;
    end
    check("R10 other sources ignored", 32'(hits), 32'h0);
    step(8'h20, o);
    check("R10 chosen source", 32'(o), 32'h04);
    wr(w_cmd(2, 0, 0, 1'b0));
  endtask

  task automatic t_independent;
    logic [NSLOT-1:0] o;
    logic [NSLOT-1:0] got [4];
    wr(w_cmd(1, 0, 1, 1'b1));
    wr(w_cmd(3, 0, 0, 1'b1));
    step(8'h01, got[0]);
    wr(w_cmd(6, 4, 2, 1'b1));
    for (int k = 1; k < 4; k++) step(8'h01, got[k]);
    check("R11 pulse 1", 32'(got[0]), 32'h08);
    check("R11 pulse 2", 32'(got[1]), 32'h0A);
    check("R11 pulse 3", 32'(got[2]), 32'h08);
    check("R11 pulse 4", 32'(got[3]), 32'h0A);
    step(8'h10, o);
    check("R11 slot 6 not yet", 32'(o), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_commit_select();
    t_forward();
    t_out_of_range();
    t_divide(0, 0, 0, 6);
    t_divide(5, 3, 3, 16);
    t_divide(7, 6, 255, 512);
    t_restart();
    t_disable();
    t_source_sel();
    t_independent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule